// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a watchdog that counts its clock in power-of-two periods and acts when software fails to restart it in time. Depending on two control bits and a configuration strap, an expiry does nothing, raises an interrupt request, pulses a system reset, or first interrupts and then resets if that interrupt is never serviced. While an external reset-cause flag is high, the reset enable cannot be turned off. This guarantees that a system recovering from a watchdog reset stays guarded.

Software uses a byte-wide control/status port with a write strobe and a live read value. The `kick` input restarts the count. The interrupt controller returns `ack` when it takes the interrupt. The reset pulse goes to the system reset generator.

Top module: `wdog_ctl`

## Requirements
- R1: On reset, `rd_data` reads 8'h00 when `rflag` is 0, and 8'h08 (reset enable set) when `rflag` is 1.
- R2: Control word layout: bit 7 is the expiry flag, bit 6 is the interrupt enable, bit 3 is the reset enable, and bits 5,2,1,0 form the 4-bit period select P (bit 5 is its MSB). Bit 4 always reads 0 and ignores writes, so writing 8'hFF reads back 8'h6F.
- R3: With `lock_n`=1, the mode follows {reset enable, interrupt enable}. 00 is stopped: an expiry has no effect. 01 is interrupt-only: an expiry sets the flag. 10 is reset-only: an expiry pulses `sys_rst`. 11 is escalating.
- R4: With `lock_n`=0, every expiry pulses `sys_rst` and never sets the flag, whatever the control bits hold.
- R5: `irq` equals the flag AND the interrupt enable.
- R6: The flag is cleared by `ack`, or by a write with bit 7 = 1. A write with bit 7 = 0 leaves it unchanged.
- R7: In escalating mode, the first expiry sets the flag. `ack` clears both the flag and the interrupt enable, which moves the block to reset-only mode. An expiry while the flag is still set pulses `sys_rst`.
- R8: While `rflag` is 1, the reset enable reads 1 and a write of 0 to it has no effect. After `rflag` falls, a write of 0 clears it.
- R9: The period is 2^(BASE_EXP+P) clocks. Values of P above SEL_MAX are treated as SEL_MAX.
- R10: A `kick`, or a write that changes P, restarts the count from zero.
- R11: `sys_rst` is high for exactly one cycle. It rises on the clock edge that ends the period, and the count restarts from zero after every expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| lock_n | input | 1 | Configuration strap; 0 forces reset-only mode |
| rflag | input | 1 | Reset-cause flag; holds the reset enable at 1 |
| kick | input | 1 | Restart the count |
| ack | input | 1 | Interrupt acknowledge |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Control word read value |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The hardest state to reach is the second expiry in escalating mode with the flag still set: the bench has to let a whole period pass without an acknowledge or a kick. The bench uses a small BASE_EXP and aligns every scenario with a kick, so the exact edge of each expiry is known and `sys_rst` is sampled on that cycle and the cycle before it. The clamp of P is reached by writing the largest select and waiting out the full clamped period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_RST  = 2'd2,
        MODE_BOTH = 2'd3
    } wd_mode_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       rst_en;
        logic [3:0] psel;
    } wd_ctrl_t;

    localparam int B_FLAG  = 7;
    localparam int B_IE    = 6;
    localparam int B_PHI   = 5;
    localparam int B_RSVD  = 4;
    localparam int B_RSTEN = 3;

    function automatic wd_mode_e mode_of(input logic lock_n, input logic rst_en,
                                         input logic ie);
        if (!lock_n) return MODE_RST;
        return wd_mode_e'({rst_en, ie});
    endfunction

    function automatic logic [3:0] psel_of(input logic [7:0] w);
        return {w[B_PHI], w[2:0]};
    endfunction

    function automatic logic [7:0] pack_csr(input wd_ctrl_t c);
        return {c.flag, c.ie, c.psel[3], 1'b0, c.rst_en, c.psel[2:0]};
    endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int BASE_EXP = 11,
    parameter int SEL_MAX  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [3:0] psel,
    output logic       tmo
);
    localparam int CW  = BASE_EXP + SEL_MAX;
    localparam int SHW = $clog2(CW + 1);

    logic [CW-1:0]  cnt;
    logic [CW-1:0]  last;
    logic [3:0]     sel_c;
    logic [SHW-1:0] shamt;

    always_comb begin
        sel_c = (psel > 4'(SEL_MAX)) ? 4'(SEL_MAX) : psel;
        shamt = SHW'(BASE_EXP) + SHW'(sel_c);
        last  = ~({CW{1'b1}} << shamt);
        tmo   = (cnt == last) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || tmo) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_act.sv
module wdog_act
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wd_mode_e mode,
    input  logic     tmo,
    input  logic     flag,
    output logic     set_flag,
    output logic     sys_rst
);
    logic fire;

    always_comb begin
        set_flag = 1'b0;
        fire     = 1'b0;
        case (mode)
            MODE_IRQ:  set_flag = tmo;
            MODE_RST:  fire     = tmo;
            MODE_BOTH: begin
                if (flag) fire     = tmo;
                else      set_flag = tmo;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sys_rst <= 1'b0;
        else     sys_rst <= fire;
    end
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rflag,
    input  logic       ack,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  wd_mode_e   mode,
    input  logic       set_flag,
    output wd_ctrl_t   ctrl,
    output logic       psel_chg
);
    wd_ctrl_t q, nxt;
    logic     unused_rsvd;

    assign unused_rsvd = wr_data[B_RSVD];

    always_comb begin
        ctrl        = q;
        ctrl.rst_en = q.rst_en | rflag;
        psel_chg    = wr_en && (psel_of(wr_data) != q.psel);
    end

    always_comb begin
        nxt = q;
        if (wr_en) begin
            if (wr_data[B_FLAG]) nxt.flag = 1'b0;
            nxt.ie     = wr_data[B_IE];
            nxt.rst_en = wr_data[B_RSTEN];
            nxt.psel   = psel_of(wr_data);
        end
        if (ack) begin
            nxt.flag = 1'b0;
            if (mode == MODE_BOTH) nxt.ie = 1'b0;
        end
        if (set_flag) nxt.flag = 1'b1;
        if (rflag)    nxt.rst_en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.rst_en <= rflag;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 11,
    parameter int SEL_MAX  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_n,
    input  logic       rflag,
    input  logic       kick,
    input  logic       ack,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       sys_rst
);
    wd_ctrl_t ctrl;
    wd_mode_e mode;
    logic     psel_chg;
    logic     tmo;
    logic     set_flag;

    assign mode    = mode_of(lock_n, ctrl.rst_en, ctrl.ie);
    assign irq     = ctrl.flag & ctrl.ie;
    assign rd_data = pack_csr(ctrl);

    wdog_tick #(.BASE_EXP(BASE_EXP), .SEL_MAX(SEL_MAX)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .restart (kick | psel_chg),
        .psel    (ctrl.psel),
        .tmo     (tmo)
    );

    wdog_csr csr_i (
        .clk      (clk),
        .rst      (rst),
        .rflag    (rflag),
        .ack      (ack),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mode     (mode),
        .set_flag (set_flag),
        .ctrl     (ctrl),
        .psel_chg (psel_chg)
    );

    wdog_act act_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .tmo      (tmo),
        .flag     (ctrl.flag),
        .set_flag (set_flag),
        .sys_rst  (sys_rst)
    );
endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       lock_n,
    input logic       rflag,
    input logic       ack,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic       sys_rst,
    input logic       tmo
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] == 1'b0);

    a_r5_irq_follows: assert property (@(posedge clk) disable iff (rst)
        irq == (rd_data[7] & rd_data[6]));

    a_r8_rflag_holds: assert property (@(posedge clk) disable iff (rst)
        rflag |-> rd_data[3]);

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> !sys_rst);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !tmo) |=> !rd_data[7]);

    a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[7] && !ack && rd_data[7]) |=> rd_data[7]);

    a_r7_escalate: assert property (@(posedge clk) disable iff (rst)
        (tmo && lock_n && rd_data[7] && rd_data[6] && rd_data[3]) |=> sys_rst);

    a_r4_strap_reset: assert property (@(posedge clk) disable iff (rst)
        (tmo && !lock_n) |=> sys_rst);
endmodule

bind wdog_ctl wdog_ctl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .lock_n  (lock_n),
    .rflag   (rflag),
    .ack     (ack),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq),
    .sys_rst (sys_rst),
    .tmo     (tmo)
);

// File: tb/wdog_ctl_tb_top.sv
module wdog_ctl_tb_top;
    localparam int BASE = 4;
    localparam int SMAX = 9;
    localparam int PER0 = 1 << BASE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lock_n = 1'b1;
    logic       rflag = 1'b0;
    logic       kick = 1'b0;
    logic       ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;
    logic       sys_rst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    wdog_ctl #(.BASE_EXP(BASE), .SEL_MAX(SMAX)) dut_i (
        .clk(clk), .rst(rst), .lock_n(lock_n), .rflag(rflag), .kick(kick),
        .ack(ack), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .sys_rst(sys_rst)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ln, input logic rf);
        lock_n = ln;
        rflag  = rf;
        rst    = 1'b1;
        waitn(2);
        rst    = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        waitn(1);
        wr_en   = 1'b0;
    endtask

    task automatic kick_t();
        kick = 1'b1;
        waitn(1);
        kick = 1'b0;
    endtask

    // fields: lock_n, rflag, ie, rst_en, exp_flag, exp_rst
    localparam logic [5:0] VEC [8] = '{
        6'b1_0_0_0_0_0,
        6'b1_0_1_0_1_0,
        6'b1_0_0_1_0_1,
        6'b1_0_1_1_1_0,
        6'b0_0_0_0_0_1,
        6'b0_0_1_0_0_1,
        6'b1_1_0_0_0_1,
        6'b1_1_1_0_1_0
    };

    initial begin
        waitn(1);

        // R3 R4 R8 R5 mode table
        for (int i = 0; i < 8; i++) begin
            logic [5:0] v;
            v = VEC[i];
            do_reset(v[5], v[4]);
            wr({1'b0, v[3], 2'b00, v[2], 3'b000});
            kick_t();
            waitn(PER0 - 1);
            chk(sys_rst == 1'b0, "R11 no early reset", sys_rst, 0);
            waitn(1);
            chk(sys_rst == v[0], "R3/R4 reset action", sys_rst, v[0]);
            chk(rd_data[7] == v[1], "R3/R4 flag action", rd_data[7], v[1]);
            chk(irq == (v[1] & v[3]), "R5 irq", irq, v[1] & v[3]);
        end

        // R1 reset state
        do_reset(1'b1, 1'b0);
        chk(rd_data == 8'h00, "R1 reset value", rd_data, 8'h00);
        do_reset(1'b1, 1'b1);
        chk(rd_data == 8'h08, "R1 reset value with rflag", rd_data, 8'h08);

        // R8 lock of reset enable
        wr(8'h00);
        chk(rd_data == 8'h08, "R8 write 0 ignored under rflag", rd_data, 8'h08);
        rflag = 1'b0;
        waitn(1);
        chk(rd_data == 8'h08, "R8 enable retained", rd_data, 8'h08);
        wr(8'h00);
        chk(rd_data == 8'h00, "R8 write 0 after rflag", rd_data, 8'h00);

        // R2 reserved bit
        do_reset(1'b1, 1'b0);
        wr(8'hFF);
        chk(rd_data == 8'h6F, "R2 readback of FF", rd_data, 8'h6F);

        // R6 flag clear rules in interrupt-only mode
        do_reset(1'b1, 1'b0);
        wr(8'h40);
        kick_t();
        waitn(PER0);
        chk(rd_data == 8'hC0, "R6 flag set", rd_data, 8'hC0);
        wr(8'h40);
        chk(rd_data[7] == 1'b1, "R6 write 0 keeps flag", rd_data[7], 1);
        wr(8'hC0);
        chk(rd_data == 8'h40, "R6 write 1 clears flag", rd_data, 8'h40);
        chk(irq == 1'b0, "R5 irq drops", irq, 0);
        kick_t();
        waitn(PER0);
        chk(irq == 1'b1, "R5 irq raised", irq, 1);
        ack = 1'b1;
        waitn(1);
        ack = 1'b0;
        chk(rd_data == 8'h40, "R6 ack clears flag only", rd_data, 8'h40);

        // R7 escalation without service
        do_reset(1'b1, 1'b0);
        wr(8'h48);
        kick_t();
        waitn(PER0);
        chk(rd_data[7] && irq && !sys_rst, "R7 first expiry interrupts", rd_data, 8'hC8);
        waitn(PER0 - 1);
        chk(sys_rst == 1'b0, "R7 no reset before second expiry", sys_rst, 0);
        waitn(1);
        chk(sys_rst == 1'b1, "R7 second expiry resets", sys_rst, 1);
        waitn(1);
        chk(sys_rst == 1'b0, "R11 pulse width", sys_rst, 0);

        // R7 acknowledge drops to reset-only
        do_reset(1'b1, 1'b0);
        wr(8'h48);
        kick_t();
        waitn(PER0);
        ack = 1'b1;
        waitn(1);
        ack = 1'b0;
        chk(rd_data == 8'h08, "R7 ack clears flag and enable", rd_data, 8'h08);
        waitn(PER0 - 2);
        chk(sys_rst == 1'b0, "R7 no reset early", sys_rst, 0);
        waitn(1);
        chk(sys_rst == 1'b1, "R7 reset after ack", sys_rst, 1);

        // R10 kick prevents expiry
        do_reset(1'b1, 1'b0);
        wr(8'h08);
        kick_t();
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < 60; k++) begin
                if (sys_rst) seen = 1'b1;
                if (k % 10 == 9) kick_t();
                else waitn(1);
            end
            chk(seen == 1'b0, "R10 kicks hold off reset", seen, 0);
        end

        // R10 R9 prescaler change restarts, period doubles
        do_reset(1'b1, 1'b0);
        wr(8'h08);
        kick_t();
        waitn(5);
        wr(8'h09);
        waitn(2 * PER0 - 1);
        chk(sys_rst == 1'b0, "R10 restart on select change", sys_rst, 0);
        waitn(1);
        chk(sys_rst == 1'b1, "R9 period for P=1", sys_rst, 1);
        waitn(1);
        chk(sys_rst == 1'b0, "R11 single pulse", sys_rst, 0);

        // R9 clamp of P=15 to SEL_MAX
        do_reset(1'b1, 1'b0);
        wr(8'h2F);
        waitn((1 << (BASE + SMAX)) - 1);
        chk(sys_rst == 1'b0, "R9 clamp no early reset", sys_rst, 0);
        waitn(1);
        chk(sys_rst == 1'b1, "R9 clamped period", sys_rst, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule